// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock of an I2C controller from a faster source clock. A prescaler turns the source clock into a count tick. Three tick counts then shape each clock period: how long SCL is released high, how long it is actively driven low, and how long the whole period lasts. The full period is set on its own. Any ticks it holds beyond the high and low counts become a hold gap, with SCL low, between the falling edge and the start of the low phase.

A bit-level engine sits beside the block and uses its strobes. The falling-edge strobe and the data-slot strobe mark where SDA may change. The rising-edge strobe marks the start of each period, where SDA is sampled. SCL is driven open-drain: `scl_oe` high pulls the line low. The sampled line comes back on `scl_in`. When a target holds the line low during the high phase, the high-phase count stalls until the line reads high. New timing values are captured only at a period boundary, or continuously while the clock is disabled.

Top module: `scl_timing_gen`

## Requirements
- R1: The timing word carries the high count in bits 29:20, the low count in bits 19:10 and the full-period count in bits 9:0, each 10 bits. A high or low count of zero acts as one.
- R2: A count tick pulses once every D source cycles, where D is the prescaler value and a value of zero acts as one. A period holds exactly high + gap + low ticks.
- R3: After each rising-edge strobe, `scl_oe` stays low for high × D source cycles, provided the line is not held low.
- R4: The full period, from one rising-edge strobe to the next, is max(cycle, high + low) × D source cycles. The low phase lasts low × D of those cycles.
- R5: The gap, max(cycle − high − low, 0) × D source cycles, separates the falling-edge strobe from the data-slot strobe. With no gap, both strobes pulse in the same cycle.
- R6: While `clk_en` is low, `scl_oe` stays low and no tick or strobe is produced.
- R7: While SCL is released but `scl_in` reads low, high-phase ticks are not counted, and `stretch_seen` is raised. Each stalled tick lengthens the high phase by one tick.
- R8: A timing word or prescaler value that changes inside a period takes effect only at the following period.
- R9: `scl_fall_stb` pulses in the first cycle of `scl_oe` high. `scl_rise_stb` pulses in the first cycle of `scl_oe` low after a low phase.
- R10: During and right after reset, `scl_oe`, `tick` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Enables serial clock generation |
| timing_word | input | 3*CNT_W | Packed high, low and full-period counts |
| div_val | input | DIV_W | Prescaler value, source cycles per tick |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Pull SCL low when high |
| tick | output | 1 | Count tick pulse |
| scl_fall_stb | output | 1 | SCL has just been pulled low |
| sda_slot_stb | output | 1 | Low phase has begun after the gap |
| scl_rise_stb | output | 1 | SCL released; a new period begins |
| stretch_seen | output | 1 | Line held low by a target during the high phase |

## Verification
The timing is swept over every combination of prescaler 1 to 3 and high and low counts 1 to 3. Each is tried with three full-period values: zero, exactly high + low, and two ticks more. These separate a missing gap, a gap taken from the wrong operand, and a period that is only high + low. The bench also runs the six tabulated bus-rate settings, whose large and unequal counts would show a field read from the wrong bits. An all-zero word and prescaler check the zero-acts-as-one rule. A change made inside a period, a stall of known length, and a disable window check that deferred loading, stretching and idling work on their own.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,
    PH_HOLD = 2'd1,
    PH_LOW  = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [3*CNT_W-1:0] timing_word,
  input  logic [DIV_W-1:0]   div_val,
  output logic [CNT_W-1:0]   high_new,
  output logic [CNT_W-1:0]   low_q,
  output logic [CNT_W-1:0]   gap_q,
  output logic [DIV_W-1:0]   div_m1_sel
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] h_raw, l_raw, c_raw, l_eff, gap_new;
  logic [SUM_W-1:0] pair_sum, cyc_ext;
  logic [DIV_W-1:0] div_m1_new, div_m1_q;

  // Field placement is fixed: high on top, low in the middle, period at the bottom.
  assign h_raw = timing_word[3*CNT_W-1:2*CNT_W];
  assign l_raw = timing_word[2*CNT_W-1:CNT_W];
  assign c_raw = timing_word[CNT_W-1:0];

  assign high_new = (h_raw == '0) ? CNT_W'(1) : h_raw;
  assign l_eff    = (l_raw == '0) ? CNT_W'(1) : l_raw;

  assign pair_sum = {1'b0, high_new} + {1'b0, l_eff};
  assign cyc_ext  = {1'b0, c_raw};
  assign gap_new  = (cyc_ext > pair_sum) ? CNT_W'(cyc_ext - pair_sum) : '0;

  assign div_m1_new = (div_val == '0) ? '0 : div_val - DIV_W'(1);
  assign div_m1_sel = load ? div_m1_new : div_m1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q    <= CNT_W'(1);
      gap_q    <= '0;
      div_m1_q <= '0;
    end else if (load) begin
      low_q    <= l_eff;
      gap_q    <= gap_new;
      div_m1_q <= div_m1_new;
    end
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick_q
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= div_m1) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_q <= 1'b0;
    end
  end

  // A divide above one never yields back-to-back ticks.
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_q && div_m1 != '0) |=> !tick_q);
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] high_new,
  input  logic [CNT_W-1:0] low_q,
  input  logic [CNT_W-1:0] gap_q,
  output logic             boundary,
  output logic             scl_oe_q,
  output logic             fall_q,
  output logic             slot_q,
  output logic             rise_q,
  output logic             stretch_q
);
  scl_phase_e       state_q, st_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             fall_n, slot_n, last;

  assign last = (rem_q == CNT_W'(1));

  always_comb begin
    st_n     = state_q;
    rem_n    = rem_q;
    fall_n   = 1'b0;
    slot_n   = 1'b0;
    boundary = 1'b0;
    case (state_q)
      PH_HIGH: if (tick && scl_in) begin
        if (last) begin
          fall_n = 1'b1;
          if (gap_q != '0) begin
            st_n  = PH_HOLD;
            rem_n = gap_q;
          end else begin
            st_n   = PH_LOW;
            rem_n  = low_q;
            slot_n = 1'b1;
          end
        end else begin
          rem_n = rem_q - CNT_W'(1);
        end
      end
      PH_HOLD: if (tick) begin
        if (last) begin
          st_n   = PH_LOW;
          rem_n  = low_q;
          slot_n = 1'b1;
        end else begin
          rem_n = rem_q - CNT_W'(1);
        end
      end
      PH_LOW: if (tick) begin
        if (last) begin
          boundary = 1'b1;
          st_n     = PH_HIGH;
          rem_n    = high_new;
        end else begin
          rem_n = rem_q - CNT_W'(1);
        end
      end
      default: begin
        st_n  = PH_HIGH;
        rem_n = high_new;
      end
    endcase
    if (!en) begin
      st_n     = PH_HIGH;
      rem_n    = high_new;
      fall_n   = 1'b0;
      slot_n   = 1'b0;
      boundary = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PH_HIGH;
      rem_q     <= CNT_W'(1);
      scl_oe_q  <= 1'b0;
      fall_q    <= 1'b0;
      slot_q    <= 1'b0;
      rise_q    <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      state_q   <= st_n;
      rem_q     <= rem_n;
      scl_oe_q  <= (st_n != PH_HIGH);
      fall_q    <= fall_n;
      slot_q    <= slot_n;
      rise_q    <= boundary;
      stretch_q <= en && (state_q == PH_HIGH) && (st_n == PH_HIGH) && !scl_in;
    end
  end

  // A tick that lands while the released line reads low is not counted.
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == PH_HIGH && tick && !scl_in) |=> (state_q == PH_HIGH && $stable(rem_q)));

  // The remaining count can never sit at zero while the clock runs.
  assert_rem_live_R3: assert property (@(posedge clk) disable iff (rst)
    en |-> rem_q != '0);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_en,
  input  logic [3*CNT_W-1:0] timing_word,
  input  logic [DIV_W-1:0]   div_val,
  input  logic               scl_in,
  output logic               scl_oe,
  output logic               tick,
  output logic               scl_fall_stb,
  output logic               sda_slot_stb,
  output logic               scl_rise_stb,
  output logic               stretch_seen
);
  logic [CNT_W-1:0] high_new, low_q, gap_q;
  logic [DIV_W-1:0] div_m1_sel;
  logic             boundary, load;

  // Shadows follow the inputs while idle and are captured again at each boundary.
  assign load = !clk_en || boundary;

  scl_cfg_shadow #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_shadow (
    .clk(clk), .rst(rst), .load(load), .timing_word(timing_word), .div_val(div_val),
    .high_new(high_new), .low_q(low_q), .gap_q(gap_q), .div_m1_sel(div_m1_sel)
  );

  scl_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .en(clk_en), .div_m1(div_m1_sel), .tick_q(tick)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en(clk_en), .tick(tick), .scl_in(scl_in),
    .high_new(high_new), .low_q(low_q), .gap_q(gap_q), .boundary(boundary),
    .scl_oe_q(scl_oe), .fall_q(scl_fall_stb), .slot_q(sda_slot_stb),
    .rise_q(scl_rise_stb), .stretch_q(stretch_seen)
  );

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> (!scl_oe && !tick && !scl_fall_stb && !sda_slot_stb && !scl_rise_stb));

  assert_fall_edge_R9: assert property (@(posedge clk) disable iff (rst)
    scl_fall_stb |-> (scl_oe && !$past(scl_oe)));

  assert_rise_edge_R9: assert property (@(posedge clk) disable iff (rst)
    scl_rise_stb |-> (!scl_oe && $past(scl_oe)));

  assert_slot_low_R5: assert property (@(posedge clk) disable iff (rst)
    sda_slot_stb |-> scl_oe);
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en = 1'b0;
  logic [3*CW-1:0] timing_word = '0;
  logic [DW-1:0] div_val = '0;
  logic hold_low = 1'b0;
  logic scl_in, scl_oe, tick, fall_stb, slot_stb, rise_stb, stretch_seen;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = !(scl_oe || hold_low);

  scl_timing_gen #(.CNT_W(CW), .DIV_W(DW)) u_scl_timing_gen (
    .clk(clk), .rst(rst), .clk_en(clk_en), .timing_word(timing_word), .div_val(div_val),
    .scl_in(scl_in), .scl_oe(scl_oe), .tick(tick), .scl_fall_stb(fall_stb),
    .sda_slot_stb(slot_stb), .scl_rise_stb(rise_stb), .stretch_seen(stretch_seen)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3*CW-1:0] pack(input int h, input int l, input int c);
    return {CW'(h), CW'(l), CW'(c)};
  endfunction

  task automatic wait_rise();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (rise_stb) break;
    end
  endtask

  // Called at a negedge showing the rising-edge strobe; returns at the next one.
  task automatic measure(input int d, input int h, input int l, input int c);
    int de, he, le, g, t0, tf, ts, tr, ticks;
    de = (d == 0) ? 1 : d;
    he = (h == 0) ? 1 : h;
    le = (l == 0) ? 1 : l;
    g  = (c > he + le) ? c - he - le : 0;
    t0 = cyc; tf = -1; ts = -1; tr = -1; ticks = 0;
    for (int k = 0; k < 5000; k++) begin
      if (tick) ticks++;
      @(negedge clk);
      if (fall_stb) tf = cyc;
      if (slot_stb) ts = cyc;
      if (rise_stb) begin tr = cyc; break; end
    end
    check("R3 high time", tf - t0, he * de);
    check("R5 gap time", ts - tf, g * de);
    check("R4 low time", tr - ts, le * de);
    check("R4 period", tr - t0, (he + g + le) * de);
    check("R2 ticks per period", ticks, he + g + le);
  endtask

  task automatic apply(input int d, input int h, input int l, input int c);
    timing_word = pack(h, l, c);
    div_val = DW'(d);
    wait_rise();
    measure(d, h, l, c);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int viol, t0, tf;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 oe in reset", int'(scl_oe), 0);
    check("R10 tick in reset", int'(tick), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 oe after reset", int'(scl_oe), 0);
    check("R10 strobes after reset", int'(fall_stb | rise_stb | slot_stb), 0);

    timing_word = pack(2, 2, 0);
    div_val = DW'(1);
    clk_en = 1'b1;
    wait_rise();

    // R1, R3, R4, R5: sweep with period zero, exact and with a gap
    for (int d = 1; d <= 3; d++)
      for (int h = 1; h <= 3; h++)
        for (int l = 1; l <= 3; l++)
          for (int ci = 0; ci < 3; ci++) begin
            int c;
            c = (ci == 0) ? 0 : (ci == 1) ? h + l : h + l + 2;
            apply(d, h, l, c);
          end

    // R1: tabulated bus-rate settings with large unequal fields
    apply(7, 10, 11, 26);
    apply(2, 5, 12, 24);
    apply(1, 3, 9, 18);
    apply(8, 14, 18, 40);
    apply(4, 3, 11, 20);
    apply(2, 3, 6, 15);
    // R1, R2: zero fields and zero prescaler act as one
    apply(0, 0, 0, 0);

    // R8: change mid-period; current period keeps old timing
    apply(2, 2, 3, 8);
    timing_word = pack(1, 1, 6);
    div_val = DW'(3);
    measure(2, 2, 3, 8);
    measure(3, 1, 1, 6);

    // R7: stretch the high phase by three ticks
    apply(1, 4, 2, 0);
    t0 = cyc;
    hold_low = 1'b1;
    @(negedge clk);
    check("R7 stretch flag", int'(stretch_seen), 1);
    check("R7 line released while held", int'(scl_oe), 0);
    @(negedge clk);
    @(negedge clk);
    hold_low = 1'b0;
    tf = -1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (fall_stb) begin tf = cyc; break; end
    end
    check("R7 stretched high time", tf - t0, 4 + 3);
    wait_rise();
    measure(1, 4, 2, 0);

    // R6: disabled clock stays idle
    @(negedge clk);
    clk_en = 1'b0;
    timing_word = pack(3, 2, 9);
    div_val = DW'(2);
    viol = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (scl_oe || tick || fall_stb || rise_stb || slot_stb) viol++;
    end
    check("R6 idle outputs", viol, 0);
    clk_en = 1'b1;
    wait_rise();
    measure(2, 3, 2, 9);

    // R9: strobe alignment over one period
    viol = 0;
    for (int k = 0; k < 40; k++) begin
      logic prev;
      prev = scl_oe;
      @(negedge clk);
      if (fall_stb != (scl_oe && !prev)) viol++;
      if (rise_stb != (!scl_oe && prev)) viol++;
    end
    check("R9 strobe alignment", viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule